// File: doc/BRIEF.md
# Data Access Translation and Fault Classifier

This block sits beside the data translation buffer of a load/store pipeline. For each load or store it takes the virtual address, the access size, the request qualifiers (store, physical, alternate-mode select, page-table access), the firmware-PC indication, the current and alternate privilege modes and the result of an external translation lookup. From these it produces the physical address, an uncacheable indication, a fault code and a six-bit memory status word. The status word tells a fault handler why the access stopped. It separates a permission violation from a fault-on-read or fault-on-write trap, flags a malformed address, and marks a translation miss.

The checks run in a fixed priority. Alignment comes first. Then come physical bypass, address well-formedness, the direct-mapped superpage window, the translation lookup with its per-mode permissions, and finally the physical-range and uncacheable decoding. One request is accepted per cycle. Its result is registered and appears on the cycle after the request. Six saturating counters track hits, misses and violations, kept separately for loads and for stores.

Top module: `dacc_classifier`

## Requirements
- R1: If VA AND (size − 1) is nonzero, the result is an alignment fault (code 1). This takes priority over every other check. The status word is 0x01 for stores and 0x00 for loads.
- R2: The effective mode equals the current mode when the firmware-PC input is low. When it is high, the effective mode is the alternate mode if the alternate-select flag is set, and kernel mode otherwise. Mode encoding: kernel 0, executive 1, supervisor 2, user 3. Permission mask bit n belongs to mode n.
- R3: With the physical flag set, the physical address is the VA itself. No lookup, permission or superpage check applies.
- R4: A VA whose bits 63:47 are not all equal raises a page fault (code 3). Its status has bad-VA (bit 5) and access violation (bit 1) set, plus the write bit (bit 0) for stores.
- R5: A VA with bits 47:41 equal to 0x7e is a superpage access. If the current-mode input is not kernel, this raises an access-violation fault (code 2) with status bit 1, plus bit 0 for stores. The check uses the current-mode input even when the firmware selects another mode. In kernel mode the PA is VA[39:0], with PA bits 43:40 copied from VA bit 40.
- R6: A lookup miss sets status bit 4, plus bit 0 for stores. It raises a page-table miss (code 5) when the page-table-access flag is set, and an ordinary miss (code 4) otherwise.
- R7: A store whose write-mask bit for the effective mode is clear raises an access violation (code 2). Its status has bits 0 and 1 set, plus fault-on-write (bit 3) when the entry's fault-on-write bit is set.
- R8: A permitted store to an entry with fault-on-write set raises a page fault (code 3) with status exactly 0x09.
- R9: Loads follow R7 and R8 using the read mask and the fault-on-read bit (status bit 2), and never set bit 0. A denied load gives 0x02, or 0x06 when the trap bit is set. A trapped load gives a page fault with status 0x04.
- R10: A lookup hit maps to PA = (page number << 13) | VA[12:0]. Any PA bit above bit 43 raises a machine check (code 6) with status 0.
- R11: A result PA with bit 43 set is flagged uncacheable and has PA bits 42:35 cleared.
- R12: The result appears one cycle after the request, with a one-cycle response strobe, and holds until the next request. On any fault the PA output is zero. After reset all outputs and counters are zero. A fault-free access has code 0 and status 0.
- R13: Six counters (load hit, miss and violation; store hit, miss and violation) each stick at their all-ones value. A hit is a superpage or lookup access that passes the permission and trap checks. A miss is a lookup miss. A violation is the fault raised under R4, R5, R7, R8 or R9. Physical and misaligned accesses count nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_va | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| req_store | input | 1 | 1 for store, 0 for load |
| req_phys | input | 1 | Physical bypass request |
| req_altsel | input | 1 | Firmware asks for the alternate mode |
| req_ptacc | input | 1 | Access is a page-table fetch |
| fw_pc | input | 1 | Issuing PC is in firmware mode |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_ppn | input | 32 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_for | input | 1 | Entry traps on read |
| tlb_fow | input | 1 | Entry traps on write |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_pa | output | 44 | Physical address, zero on a fault |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_fault | output | 3 | Fault code |
| rsp_status | output | 6 | Memory status word |
| cnt_rd_hit | output | 8 | Load hit count |
| cnt_rd_miss | output | 8 | Load miss count |
| cnt_rd_viol | output | 8 | Load violation count |
| cnt_wr_hit | output | 8 | Store hit count |
| cnt_wr_miss | output | 8 | Store miss count |
| cnt_wr_viol | output | 8 | Store violation count |

## Verification
The bench sends a misaligned store with a malformed address. A design that checked the address before alignment would report a page fault there. It exercises a firmware access with the current mode at user against the superpage window. A design that used the firmware-selected mode would map that access instead of raising a violation. It separates a permission denial from a fault-on trap. A design that swapped the priority would return 0x09 where 0x0B is due, or set the write bit on loads. It drives page numbers that cross bit 44 and that set bits 42:35, and it pushes two counters past their limit. A design with a wrong range test or a wrapping counter would show a wrong code, leftover PA bits or a counter back at zero.

// File: rtl/dacc_pkg.sv
// Shared types and status-bit positions for the data access classifier.
// Assumes a four-level privilege encoding with kernel at zero.
package dacc_pkg;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ALIGN  = 3'd1,
        FLT_ACV    = 3'd2,
        FLT_PAGE   = 3'd3,
        FLT_MISS   = 3'd4,
        FLT_PTMISS = 3'd5,
        FLT_MCHK   = 3'd6
    } fault_e;

    typedef enum logic [1:0] {
        MODE_KERN = 2'd0,
        MODE_EXEC = 2'd1,
        MODE_SUPV = 2'd2,
        MODE_USER = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_HIT  = 2'd1,
        CLS_MISS = 2'd2,
        CLS_VIOL = 2'd3
    } cls_e;

    localparam int NUM_MODES = 4;
    localparam int ST_W      = 6;
    localparam int ST_WR     = 0;
    localparam int ST_ACV    = 1;
    localparam int ST_FONR   = 2;
    localparam int ST_FONW   = 3;
    localparam int ST_MISS   = 4;
    localparam int ST_BADVA  = 5;
    localparam int NUM_CNT   = 6;
    localparam int CNT_KINDS = 3;

endpackage

// File: rtl/dacc_mode_sel.sv
// Effective privilege mode selection.
// Firmware code runs in kernel mode unless it asks for the alternate mode;
// all other code runs in the current mode. Purely combinational.
module dacc_mode_sel
    import dacc_pkg::*;
(
    input  logic       fw_pc,
    input  logic       altsel,
    input  logic [1:0] cur_mode,
    input  logic [1:0] alt_mode,
    output logic [1:0] eff_mode
);

    // Pick the mode that governs permission checks.
    always_comb begin
        if (!fw_pc)
            eff_mode = cur_mode;
        else if (altsel)
            eff_mode = alt_mode;
        else
            eff_mode = MODE_KERN;
    end

endmodule

// File: rtl/dacc_perm_chk.sv
// Permission and trap check for an access that hit in the lookup.
// Assumes the masks carry one bit per mode, indexed by the mode code.
// A denial takes priority over a fault-on trap; the trap bit is still
// reported with a denial so the handler sees both causes.
module dacc_perm_chk
    import dacc_pkg::*;
(
    input  logic                 store,
    input  logic [1:0]           mode,
    input  logic [NUM_MODES-1:0] rd_en,
    input  logic [NUM_MODES-1:0] wr_en,
    input  logic                 fonr,
    input  logic                 fonw,
    output fault_e               fault,
    output logic [ST_W-1:0]      status
);

    logic allowed;
    logic trap;

    // Select the mask bit and trap bit for the access direction.
    always_comb begin
        allowed = store ? wr_en[mode] : rd_en[mode];
        trap    = store ? fonw : fonr;
    end

    // Classify into denial, trap or pass and build the status word.
    always_comb begin
        fault  = FLT_NONE;
        status = '0;
        if (!allowed) begin
            fault          = FLT_ACV;
            status[ST_ACV] = 1'b1;
            status[ST_WR]  = store;
            if (store) status[ST_FONW] = fonw;
            else       status[ST_FONR] = fonr;
        end else if (trap) begin
            fault         = FLT_PAGE;
            status[ST_WR] = store;
            if (store) status[ST_FONW] = 1'b1;
            else       status[ST_FONR] = 1'b1;
        end
    end

endmodule

// File: rtl/dacc_pa_fmt.sv
// Physical address range check and uncacheable decoding.
// Takes a wide raw address and flags any bit above the implemented width.
// The top implemented bit marks uncacheable space; in that case a field
// below it is cleared. Purely combinational.
module dacc_pa_fmt #(
    parameter int RAW_W     = 64,
    parameter int PA_W      = 44,
    parameter int UC_CLR_LO = 35
) (
    input  logic [RAW_W-1:0] raw,
    output logic             over_range,
    output logic             uncached,
    output logic [PA_W-1:0]  pa
);

    // Range test, uncacheable decode and field clearing.
    always_comb begin
        over_range = |raw[RAW_W-1:PA_W];
        uncached   = raw[PA_W-1];
        pa         = raw[PA_W-1:0];
        if (uncached)
            pa[PA_W-2:UC_CLR_LO] = '0;
    end

endmodule

// File: rtl/dacc_sat_cnt.sv
// Saturating event counter: increments by one per event and sticks at
// its all-ones value. Synchronous active-low reset.
module dacc_sat_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count events until the ceiling is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != CNT_MAX)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/dacc_classifier.sv
// Data access translation and fault classifier (top).
// Accepts one load/store per cycle, applies the checks in priority order
// (alignment, physical bypass, address form, superpage window, lookup and
// permissions, physical range) and registers the physical address, the
// uncacheable flag, the fault code and the status word one cycle later.
// Assumes the lookup result on the tlb_* inputs belongs to req_va in the
// same cycle. Six saturating counters record hits, misses and violations.
module dacc_classifier
    import dacc_pkg::*;
#(
    parameter int           VA_W       = 64,
    parameter int           PA_W       = 44,
    parameter int           PPN_W      = 32,
    parameter int           PAGE_SHIFT = 13,
    parameter int           SIZE_W     = 4,
    parameter int           VA_SIGN    = 47,
    parameter int           SP_HI      = 47,
    parameter int           SP_LO      = 41,
    parameter logic [6:0]   SP_TAG     = 7'h7e,
    parameter int           SP_EXT     = 40,
    parameter int           UC_CLR_LO  = 35,
    parameter int           CNT_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_va,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic                 req_store,
    input  logic                 req_phys,
    input  logic                 req_altsel,
    input  logic                 req_ptacc,
    input  logic                 fw_pc,
    input  logic [1:0]           cur_mode,
    input  logic [1:0]           alt_mode,
    input  logic                 tlb_hit,
    input  logic [PPN_W-1:0]     tlb_ppn,
    input  logic [NUM_MODES-1:0] tlb_rd_en,
    input  logic [NUM_MODES-1:0] tlb_wr_en,
    input  logic                 tlb_for,
    input  logic                 tlb_fow,
    output logic                 rsp_valid,
    output logic [PA_W-1:0]      rsp_pa,
    output logic                 rsp_uncached,
    output logic [2:0]           rsp_fault,
    output logic [ST_W-1:0]      rsp_status,
    output logic [CNT_W-1:0]     cnt_rd_hit,
    output logic [CNT_W-1:0]     cnt_rd_miss,
    output logic [CNT_W-1:0]     cnt_rd_viol,
    output logic [CNT_W-1:0]     cnt_wr_hit,
    output logic [CNT_W-1:0]     cnt_wr_miss,
    output logic [CNT_W-1:0]     cnt_wr_viol
);

    localparam int TLB_RAW_W = PPN_W + PAGE_SHIFT;
    localparam int RAW_W     = (VA_W > TLB_RAW_W) ? VA_W : TLB_RAW_W;
    localparam int SP_W      = SP_HI - SP_LO + 1;

    // ---------------- effective mode ----------------
    logic [1:0] eff_mode;

    dacc_mode_sel u_mode (
        .fw_pc    (fw_pc),
        .altsel   (req_altsel),
        .cur_mode (cur_mode),
        .alt_mode (alt_mode),
        .eff_mode (eff_mode)
    );

    // ---------------- permission check ----------------
    fault_e          perm_fault;
    logic [ST_W-1:0] perm_status;

    dacc_perm_chk u_perm (
        .store  (req_store),
        .mode   (eff_mode),
        .rd_en  (tlb_rd_en),
        .wr_en  (tlb_wr_en),
        .fonr   (tlb_for),
        .fonw   (tlb_fow),
        .fault  (perm_fault),
        .status (perm_status)
    );

    // ---------------- address decode ----------------
    logic             misaligned;
    logic             va_ok;
    logic             in_sp;
    logic [RAW_W-1:0] phys_raw;
    logic [RAW_W-1:0] sp_raw;
    logic [RAW_W-1:0] tlb_raw;

    // Alignment, address form and superpage window tests.
    always_comb begin
        misaligned = |(req_va[SIZE_W-1:0] & (req_size - 1'b1));
        va_ok      = (&req_va[VA_W-1:VA_SIGN]) | ~(|req_va[VA_W-1:VA_SIGN]);
        in_sp      = (req_va[SP_HI:SP_LO] == SP_TAG[SP_W-1:0]);
    end

    // Candidate raw physical addresses for the three mapping paths.
    always_comb begin
        phys_raw = RAW_W'(req_va);
        tlb_raw  = (RAW_W'(tlb_ppn) << PAGE_SHIFT) | RAW_W'(req_va[PAGE_SHIFT-1:0]);
        for (int i = 0; i < RAW_W; i++) begin
            if (i < SP_EXT)
                sp_raw[i] = req_va[i];
            else if (i < PA_W)
                sp_raw[i] = req_va[SP_EXT];
            else
                sp_raw[i] = 1'b0;
        end
    end

    // ---------------- classification ----------------
    fault_e           pre_fault;
    logic [ST_W-1:0]  pre_status;
    logic [RAW_W-1:0] sel_raw;
    cls_e             cls;

    // Apply the checks in priority order ahead of the range check.
    always_comb begin
        pre_fault  = FLT_NONE;
        pre_status = '0;
        sel_raw    = phys_raw;
        cls        = CLS_NONE;
        if (misaligned) begin
            pre_fault         = FLT_ALIGN;
            pre_status[ST_WR] = req_store;
        end else if (req_phys) begin
            sel_raw = phys_raw;
        end else if (!va_ok) begin
            pre_fault            = FLT_PAGE;
            pre_status[ST_WR]    = req_store;
            pre_status[ST_ACV]   = 1'b1;
            pre_status[ST_BADVA] = 1'b1;
            cls                  = CLS_VIOL;
        end else if (in_sp) begin
            if (cur_mode != MODE_KERN) begin
                pre_fault          = FLT_ACV;
                pre_status[ST_WR]  = req_store;
                pre_status[ST_ACV] = 1'b1;
                cls                = CLS_VIOL;
            end else begin
                sel_raw = sp_raw;
                cls     = CLS_HIT;
            end
        end else if (!tlb_hit) begin
            pre_fault           = req_ptacc ? FLT_PTMISS : FLT_MISS;
            pre_status[ST_WR]   = req_store;
            pre_status[ST_MISS] = 1'b1;
            cls                 = CLS_MISS;
        end else begin
            pre_fault  = perm_fault;
            pre_status = perm_status;
            sel_raw    = tlb_raw;
            cls        = (perm_fault == FLT_NONE) ? CLS_HIT : CLS_VIOL;
        end
    end

    // ---------------- physical range and cacheability ----------------
    logic            over_range;
    logic            pa_uc;
    logic [PA_W-1:0] pa_fmt;

    dacc_pa_fmt #(
        .RAW_W     (RAW_W),
        .PA_W      (PA_W),
        .UC_CLR_LO (UC_CLR_LO)
    ) u_pafmt (
        .raw        (sel_raw),
        .over_range (over_range),
        .uncached   (pa_uc),
        .pa         (pa_fmt)
    );

    fault_e          fin_fault;
    logic            fin_ok;

    // Promote an out-of-range address to a machine check.
    always_comb begin
        fin_fault = pre_fault;
        if (pre_fault == FLT_NONE && over_range)
            fin_fault = FLT_MCHK;
        fin_ok = (fin_fault == FLT_NONE);
    end

    // ---------------- result register ----------------
    // Capture the classified result one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            rsp_fault    <= FLT_NONE;
            rsp_status   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa       <= fin_ok ? pa_fmt : '0;
                rsp_uncached <= fin_ok & pa_uc;
                rsp_fault    <= fin_fault;
                rsp_status   <= pre_status;
            end
        end
    end

    // ---------------- event counters ----------------
    logic [CNT_W-1:0] cnt_bus [NUM_CNT];

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam logic G_STORE = (g >= CNT_KINDS);
        localparam cls_e G_CLS   = cls_e'((g % CNT_KINDS) + 1);
        logic inc;
        assign inc = req_valid && (req_store == G_STORE) && (cls == G_CLS);
        dacc_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc),
            .count (cnt_bus[g])
        );
    end

    assign cnt_rd_hit  = cnt_bus[0];
    assign cnt_rd_miss = cnt_bus[1];
    assign cnt_rd_viol = cnt_bus[2];
    assign cnt_wr_hit  = cnt_bus[3];
    assign cnt_wr_miss = cnt_bus[4];
    assign cnt_wr_viol = cnt_bus[5];

endmodule

// File: rtl/dacc_classifier_chk.sv
// Property checker for the data access classifier, attached by bind.
// Observes the top-level ports only.
module dacc_classifier_chk
    import dacc_pkg::*;
#(
    parameter int PA_W      = 44,
    parameter int UC_CLR_LO = 35,
    parameter int CNT_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_store,
    input logic                 rsp_valid,
    input logic [PA_W-1:0]      rsp_pa,
    input logic                 rsp_uncached,
    input logic [2:0]           rsp_fault,
    input logic [ST_W-1:0]      rsp_status,
    input logic [CNT_W-1:0]     cnt_rd_hit,
    input logic [CNT_W-1:0]     cnt_rd_miss,
    input logic [CNT_W-1:0]     cnt_rd_viol,
    input logic [CNT_W-1:0]     cnt_wr_hit,
    input logic [CNT_W-1:0]     cnt_wr_miss,
    input logic [CNT_W-1:0]     cnt_wr_viol
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R12: strobe follows the request by exactly one cycle.
    a_r12_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(req_valid));

    // R12: no address escapes on a fault.
    a_r12_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 3'(FLT_NONE) |-> rsp_pa == '0 && !rsp_uncached);

    // R12: a clean access reports an empty status word.
    a_r12_clean_status: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault == 3'(FLT_NONE) |-> rsp_status == '0);

    // R1: alignment fault carries at most the write bit.
    a_r1_align_status: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault == 3'(FLT_ALIGN) |-> rsp_status[ST_W-1:1] == '0);

    // R6: miss faults carry the miss bit and no other cause.
    a_r6_miss_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault == 3'(FLT_MISS) || rsp_fault == 3'(FLT_PTMISS))
        |-> rsp_status[ST_MISS] && $countones(rsp_status[ST_W-1:1]) == 1);

    // R10: machine check carries an empty status word.
    a_r10_mchk_status: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault == 3'(FLT_MCHK) |-> rsp_status == '0);

    // R7 / R9: write bit on every non-machine-check fault matches the direction.
    a_r7_wr_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'(FLT_NONE) && rsp_fault != 3'(FLT_MCHK))
        |-> rsp_status[ST_WR] == $past(req_store));

    // R9: a load never reports fault-on-write.
    a_r9_load_no_fonw: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(req_store)) |-> !rsp_status[ST_FONW]);

    // R11: uncacheable addresses keep the top bit and lose the cleared field.
    a_r11_uc_field: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_uncached |-> rsp_pa[PA_W-1] && rsp_pa[PA_W-2:UC_CLR_LO] == '0);

    logic [CNT_W-1:0] cnts [6];
    assign cnts[0] = cnt_rd_hit;
    assign cnts[1] = cnt_rd_miss;
    assign cnts[2] = cnt_rd_viol;
    assign cnts[3] = cnt_wr_hit;
    assign cnts[4] = cnt_wr_miss;
    assign cnts[5] = cnt_wr_viol;

    for (genvar g = 0; g < 6; g++) begin : g_cnt_chk
        // R13: a saturated counter stays saturated.
        a_r13_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
            cnts[g] == CNT_MAX |=> cnts[g] == CNT_MAX);
        // R13: counters move by at most one per cycle and never back.
        a_r13_step: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (cnts[g] == $past(cnts[g]) || cnts[g] == $past(cnts[g]) + 1'b1));
    end

endmodule

bind dacc_classifier dacc_classifier_chk #(
    .PA_W      (PA_W),
    .UC_CLR_LO (UC_CLR_LO),
    .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/dacc_classifier_tb.sv
`timescale 1ns/1ps
module dacc_classifier_tb;
    import dacc_pkg::*;

    localparam int CW = 3;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [3:0]  req_size = 4'd1;
    logic        req_store = 1'b0;
    logic        req_phys = 1'b0;
    logic        req_altsel = 1'b0;
    logic        req_ptacc = 1'b0;
    logic        fw_pc = 1'b0;
    logic [1:0]  cur_mode = 2'd0;
    logic [1:0]  alt_mode = 2'd0;
    logic        tlb_hit = 1'b0;
    logic [31:0] tlb_ppn = '0;
    logic [3:0]  tlb_rd_en = '0;
    logic [3:0]  tlb_wr_en = '0;
    logic        tlb_for = 1'b0;
    logic        tlb_fow = 1'b0;
    logic        rsp_valid;
    logic [43:0] rsp_pa;
    logic        rsp_uncached;
    logic [2:0]  rsp_fault;
    logic [5:0]  rsp_status;
    logic [CW-1:0] cnt_rd_hit, cnt_rd_miss, cnt_rd_viol;
    logic [CW-1:0] cnt_wr_hit, cnt_wr_miss, cnt_wr_viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_cnt [6];

    always #10 clk = ~clk;

    dacc_classifier #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_size(req_size), .req_store(req_store), .req_phys(req_phys),
        .req_altsel(req_altsel), .req_ptacc(req_ptacc), .fw_pc(fw_pc),
        .cur_mode(cur_mode), .alt_mode(alt_mode), .tlb_hit(tlb_hit),
        .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
        .tlb_for(tlb_for), .tlb_fow(tlb_fow), .rsp_valid(rsp_valid),
        .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault),
        .rsp_status(rsp_status), .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
        .cnt_rd_viol(cnt_rd_viol), .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss),
        .cnt_wr_viol(cnt_wr_viol)
    );

    // Bump an expected counter with saturation (0..2 loads, 3..5 stores).
    task automatic bump(input int idx);
        if (exp_cnt[idx] < CMAX) exp_cnt[idx]++;
    endtask

    // Return inputs to a neutral load in kernel mode.
    task automatic idle_inputs();
        req_va = '0; req_size = 4'd1; req_store = 1'b0; req_phys = 1'b0;
        req_altsel = 1'b0; req_ptacc = 1'b0; fw_pc = 1'b0; cur_mode = 2'd0;
        alt_mode = 2'd0; tlb_hit = 1'b0; tlb_ppn = '0; tlb_rd_en = '0;
        tlb_wr_en = '0; tlb_for = 1'b0; tlb_fow = 1'b0;
    endtask

    // Present one request for one cycle and return at the sampling edge.
    task automatic fire();
        @(negedge clk) req_valid = 1'b1;
        @(negedge clk) req_valid = 1'b0;
    endtask

    // Compare the registered result against the expected values.
    task automatic check_rsp(input string tag, input logic [2:0] ef,
                             input logic [5:0] es, input logic [43:0] epa,
                             input logic euc);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_fault !== ef || rsp_status !== es ||
            rsp_pa !== epa || rsp_uncached !== euc) begin
            errors++;
            $display("FAIL %s: got v=%0b f=%0d st=%02h pa=%011h uc=%0b, expected v=1 f=%0d st=%02h pa=%011h uc=%0b",
                     tag, rsp_valid, rsp_fault, rsp_status, rsp_pa, rsp_uncached,
                     ef, es, epa, euc);
        end
    endtask

    // Compare all six counters with the bench model.
    task automatic check_counts(input string tag);
        int act [6];
        act[0] = cnt_rd_hit; act[1] = cnt_rd_miss; act[2] = cnt_rd_viol;
        act[3] = cnt_wr_hit; act[4] = cnt_wr_miss; act[5] = cnt_wr_viol;
        for (int i = 0; i < 6; i++) begin
            checks++;
            if (act[i] != exp_cnt[i]) begin
                errors++;
                $display("FAIL R13 %s counter %0d: got %0d expected %0d", tag, i, act[i], exp_cnt[i]);
            end
        end
    endtask

    // R12: reset state of every output.
    task automatic t_reset();
        checks++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 3'd0 || rsp_status !== 6'd0 ||
            rsp_pa !== '0 || rsp_uncached !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset: got v=%0b f=%0d st=%02h pa=%011h uc=%0b expected all zero",
                     rsp_valid, rsp_fault, rsp_status, rsp_pa, rsp_uncached);
        end
        check_counts("reset");
    endtask

    // R1: alignment beats everything, write bit only for stores.
    task automatic t_align();
        idle_inputs();
        req_va = 64'h0001_0000_0000_0004; req_size = 4'd8; req_store = 1'b1;
        fire(); check_rsp("R1 store misaligned bad VA", FLT_ALIGN, 6'h01, '0, 1'b0);
        idle_inputs();
        req_va = 64'h0000_0000_0000_1001; req_size = 4'd2;
        fire(); check_rsp("R1 load misaligned", FLT_ALIGN, 6'h00, '0, 1'b0);
        idle_inputs();
        req_va = 64'h0000_0000_0000_1008; req_size = 4'd4; req_phys = 1'b1;
        fire(); check_rsp("R1 aligned passes", FLT_NONE, 6'h00, 44'h000_0000_1008, 1'b0);
        check_counts("R1");
    endtask

    // R3, R10, R11: physical bypass.
    task automatic t_phys();
        idle_inputs();
        req_phys = 1'b1; req_size = 4'd8; req_va = 64'h0000_0001_2345_6788;
        fire(); check_rsp("R3 physical map", FLT_NONE, 6'h00, 44'h001_2345_6788, 1'b0);
        req_va = 64'h0004_0000_0000_0000;
        fire(); check_rsp("R10 physical over range", FLT_MCHK, 6'h00, '0, 1'b0);
        req_va = 64'h0000_0FF8_0000_1000;
        fire(); check_rsp("R11 physical uncached", FLT_NONE, 6'h00, 44'h800_0000_1000, 1'b1);
        check_counts("R3");
    endtask

    // R4: malformed addresses.
    task automatic t_badva();
        idle_inputs();
        req_va = 64'h0001_0000_0000_0000; req_store = 1'b1; tlb_hit = 1'b1;
        tlb_wr_en = 4'hF; tlb_rd_en = 4'hF;
        fire(); check_rsp("R4 store bad VA", FLT_PAGE, 6'h23, '0, 1'b0); bump(5);
        req_store = 1'b0; req_va = 64'hFFFE_0000_0000_0000 ^ 64'h8000_0000_0000_0000;
        fire(); check_rsp("R4 load bad VA", FLT_PAGE, 6'h22, '0, 1'b0); bump(2);
        check_counts("R4");
    endtask

    // R5: superpage window.
    task automatic t_superpage();
        idle_inputs();
        req_va = 64'hFFFF_FC00_0001_2340;
        fire(); check_rsp("R5 kernel superpage", FLT_NONE, 6'h00, 44'h000_0001_2340, 1'b0); bump(0);
        req_va = 64'hFFFF_FD00_0001_2340;
        fire(); check_rsp("R5 R11 superpage sign ext", FLT_NONE, 6'h00, 44'h800_0001_2340, 1'b1); bump(0);
        req_va = 64'hFFFF_FC00_0001_2340; req_store = 1'b1; cur_mode = 2'd3;
        fire(); check_rsp("R5 user superpage store", FLT_ACV, 6'h03, '0, 1'b0); bump(5);
        fw_pc = 1'b1;
        fire(); check_rsp("R5 firmware uses current mode", FLT_ACV, 6'h03, '0, 1'b0); bump(5);
        check_counts("R5");
    endtask

    // R6: miss flavours.
    task automatic t_miss();
        idle_inputs();
        req_va = 64'h0000_0000_0020_00A8;
        fire(); check_rsp("R6 load miss", FLT_MISS, 6'h10, '0, 1'b0); bump(1);
        req_store = 1'b1; req_ptacc = 1'b1;
        fire(); check_rsp("R6 store page-table miss", FLT_PTMISS, 6'h11, '0, 1'b0); bump(4);
        check_counts("R6");
    endtask

    // R7, R8: store permissions and fault-on-write.
    task automatic t_store_perm();
        idle_inputs();
        req_va = 64'h0000_0000_0020_00A8; req_store = 1'b1; req_size = 4'd8;
        cur_mode = 2'd3; tlb_hit = 1'b1; tlb_ppn = 32'h1234;
        tlb_wr_en = 4'b0111; tlb_fow = 1'b1;
        fire(); check_rsp("R7 denied store with trap", FLT_ACV, 6'h0B, '0, 1'b0); bump(5);
        tlb_fow = 1'b0;
        fire(); check_rsp("R7 denied store", FLT_ACV, 6'h03, '0, 1'b0); bump(5);
        tlb_wr_en = 4'b1000; tlb_fow = 1'b1;
        fire(); check_rsp("R8 trapped store", FLT_PAGE, 6'h09, '0, 1'b0); bump(5);
        tlb_fow = 1'b0;
        fire(); check_rsp("R10 store hit", FLT_NONE, 6'h00, 44'h000_0246_80A8, 1'b0); bump(3);
        check_counts("R7");
    endtask

    // R9: load permissions and fault-on-read.
    task automatic t_load_perm();
        idle_inputs();
        req_va = 64'h0000_0000_0020_00A8; req_size = 4'd8;
        cur_mode = 2'd3; tlb_hit = 1'b1; tlb_ppn = 32'h1234;
        tlb_rd_en = 4'b0111; tlb_wr_en = 4'hF; tlb_for = 1'b1; tlb_fow = 1'b1;
        fire(); check_rsp("R9 denied load with trap", FLT_ACV, 6'h06, '0, 1'b0); bump(2);
        tlb_rd_en = 4'b1000;
        fire(); check_rsp("R9 trapped load", FLT_PAGE, 6'h04, '0, 1'b0); bump(2);
        tlb_for = 1'b0;
        fire(); check_rsp("R9 load hit ignores write trap", FLT_NONE, 6'h00, 44'h000_0246_80A8, 1'b0); bump(0);
        check_counts("R9");
    endtask

    // R2: effective mode selection.
    task automatic t_mode();
        idle_inputs();
        req_va = 64'h0000_0000_0020_00A8; tlb_hit = 1'b1; tlb_ppn = 32'h1234;
        fw_pc = 1'b1; cur_mode = 2'd3; alt_mode = 2'd2; tlb_rd_en = 4'b0001;
        fire(); check_rsp("R2 firmware kernel", FLT_NONE, 6'h00, 44'h000_0246_80A8, 1'b0); bump(0);
        req_altsel = 1'b1;
        fire(); check_rsp("R2 firmware alternate denied", FLT_ACV, 6'h02, '0, 1'b0); bump(2);
        tlb_rd_en = 4'b0100;
        fire(); check_rsp("R2 firmware alternate allowed", FLT_NONE, 6'h00, 44'h000_0246_80A8, 1'b0); bump(0);
        fw_pc = 1'b0; cur_mode = 2'd1; tlb_rd_en = 4'b0010;
        fire(); check_rsp("R2 current mode", FLT_NONE, 6'h00, 44'h000_0246_80A8, 1'b0); bump(0);
        check_counts("R2");
    endtask

    // R10, R11: lookup-derived physical addresses.
    task automatic t_tlb_pa();
        idle_inputs();
        req_va = 64'h0000_0000_0020_0010; tlb_hit = 1'b1; tlb_rd_en = 4'hF;
        tlb_ppn = 32'h8000_0000;
        fire(); check_rsp("R10 lookup over range", FLT_MCHK, 6'h00, '0, 1'b0); bump(0);
        tlb_ppn = 32'h7FC0_0001;
        fire(); check_rsp("R11 lookup uncached clear", FLT_NONE, 6'h00, 44'h800_0000_2010, 1'b1); bump(0);
        check_counts("R10");
    endtask

    // R12: idle cycles keep the result and drop the strobe.
    task automatic t_hold();
        idle_inputs();
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_pa !== 44'h800_0000_2010 || rsp_uncached !== 1'b1) begin
            errors++;
            $display("FAIL R12 hold: got v=%0b pa=%011h uc=%0b expected v=0 pa=80000002010 uc=1",
                     rsp_valid, rsp_pa, rsp_uncached);
        end
        check_counts("R12 hold");
    endtask

    // R13: drive a counter well past its ceiling.
    task automatic t_sat();
        idle_inputs();
        req_va = 64'h0000_0000_0030_0000;
        for (int i = 0; i < 10; i++) begin
            fire(); bump(1);
        end
        check_counts("R13 saturation");
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_align();
        t_phys();
        t_badva();
        t_superpage();
        t_miss();
        t_store_perm();
        t_load_perm();
        t_mode();
        t_tlb_pa();
        t_hold();
        t_sat();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: bench did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule